// File: doc/BRIEF.md
# Burst Column Sequencer with Latency Timer

This block sits on the controller side of a memory that takes each access as two commands. An access command, which carries a direction bit (read or write with auto-close) and the starting column, is followed some cycles later by a latch command. The latency is counted from the latch command. When it runs out, the block opens a four-cycle read capture window or a four-cycle write data request. On each of those four beats it drives a beat index and the two low column address bits.

A mode register holds a 3-bit latency code and a burst-type bit. It is written only while no access is in progress. Latency codes 4 to 7 are legal and give a latency equal to the code value. Codes 0 to 3 are reserved: while one of them is held, the block raises its error flag and refuses all accesses. The burst is always four words long, so the beat address wraps inside the aligned group of four columns. In sequential order it counts upward from the start column. In interleaved order it XORs the start column with the beat number.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, rd_valid, wr_req and err are low, beat_idx and col_lo are 0, and the mode register holds latency 4 in sequential order.
- R2: For a read, rd_valid is high for exactly 4 consecutive cycles. The first of these is L cycles after the cycle in which the accepted latch command is sampled. L is the value of the 3-bit code (binary 1xx, giving 4 to 7). The gap between the access command and the latch command does not change this count.
- R3: For a write, wr_req is high for exactly 4 consecutive cycles starting L-1 cycles after the latch cycle. rd_valid and wr_req are never high together.
- R4: During a burst, beat_idx reads 0, 1, 2, 3 on consecutive cycles.
- R5: With burst type 0 (sequential), col_lo on beat k equals (start + k) mod 4, where start is the 2-bit column given with the access command.
- R6: With burst type 1 (interleaved), col_lo on beat k equals start XOR k.
- R7: Loading a reserved code (bit 2 of the code = 0) sets err on the next cycle. While such a code is held, access commands are ignored. Loading a legal code clears err.
- R8: A latch command that arrives with no pending access command is ignored, and no burst follows.
- R9: An access command that arrives while an access is pending, counting or bursting is ignored, and err is set. The access already under way completes unchanged, and err stays set until the next legal mode load.
- R10: A mode load that arrives while an access is pending, counting or bursting is ignored. Later bursts keep the previous latency and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Mode register write strobe |
| mode_lat_code | input | 3 | Latency code; 1xx gives latency 4..7 |
| mode_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| acc_cmd | input | 1 | First (access) command strobe |
| acc_write | input | 1 | Direction with acc_cmd: 1 write, 0 read |
| col_start | input | 2 | Low two bits of the starting column |
| latch_cmd | input | 1 | Second (latch) command strobe |
| rd_valid | output | 1 | Read capture window, one cycle per beat |
| wr_req | output | 1 | Write data request, one cycle per beat |
| beat_idx | output | 2 | Beat number within the burst |
| col_lo | output | 2 | Low column address bits for the current beat |
| err | output | 1 | Reserved latency code held, or command collision |

## Verification
When latch_cmd is driven in bench cycle N, read beats are due in cycles N+L to N+L+3 and write beats in cycles N+L-1 to N+L+2. A mode load or a rejected access command shows on err in cycle N+1. The driver computes the cycle number, direction, beat index and column for every beat and queues them. The monitor samples once per cycle, 2 ns after the rising edge. It pops one entry for each active output cycle and compares the cycle number too, so a beat that comes early or late fails. Any output cycle with nothing queued is reported as an unexpected burst. This is how the ignored latch commands, access commands and reserved-code cases are observed at the ports.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Latency code width; legal codes have the top bit set
    localparam int LAT_W   = 3;
    // Fixed burst of four words
    localparam int BURST_N = 4;
    localparam int BEAT_W  = $clog2(BURST_N);
    localparam int CNT_W   = LAT_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_BURST = 2'd3
    } bcs_state_e;

    typedef struct packed {
        logic [LAT_W-1:0] code;
        logic             il;
    } bcs_mode_s;

    typedef struct packed {
        bcs_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic              wr;
        logic [BEAT_W-1:0] start;
        logic              err;
    } bcs_ctrl_s;

    function automatic logic lat_code_ok(input logic [LAT_W-1:0] code);
        return code[LAT_W-1];
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter logic [LAT_W-1:0] RST_CODE = 3'd4,
    parameter logic             RST_IL   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] code_in,
    input  logic             il_in,
    input  logic             allow,
    output logic [LAT_W-1:0] code_q,
    output logic             il_q,
    output logic             valid_q,
    output logic             load_ok,
    output logic             load_bad
);

    bcs_mode_s mode_d, mode_q;
    logic      take;

    always_comb begin
        mode_d = mode_q;
        take   = load && allow;
        if (take) begin
            mode_d.code = code_in;
            mode_d.il   = il_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q.code <= RST_CODE;
            mode_q.il   <= RST_IL;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign code_q   = mode_q.code;
    assign il_q     = mode_q.il;
    assign valid_q  = lat_code_ok(mode_q.code);
    assign load_ok  = take && lat_code_ok(code_in);
    assign load_bad = take && !lat_code_ok(code_in);

endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_cmd,
    input  logic              acc_write,
    input  logic [BEAT_W-1:0] col_start,
    input  logic              latch_cmd,
    input  logic [LAT_W-1:0]  lat_code,
    input  logic              mode_valid,
    input  logic              load_ok,
    input  logic              load_bad,
    output logic              idle,
    output logic              armed,
    output logic              active,
    output logic              wr,
    output logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] start,
    output logic              err
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_N - 1);

    bcs_ctrl_s ctl_d, ctl_q;
    logic [CNT_W-1:0] delay;

    // Cycles from latch to first beat; write data is due one cycle sooner
    always_comb begin
        delay = ctl_q.wr ? (lat_code - CNT_W'(1)) : lat_code;
    end

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (acc_cmd && mode_valid) begin
                    ctl_d.state = ST_ARMED;
                    ctl_d.wr    = acc_write;
                    ctl_d.start = col_start;
                end
            end
            ST_ARMED: begin
                if (acc_cmd) begin
                    ctl_d.err = 1'b1;
                end
                if (latch_cmd) begin
                    ctl_d.state = ST_COUNT;
                    ctl_d.cnt   = delay - CNT_W'(2);
                end
            end
            ST_COUNT: begin
                if (acc_cmd) begin
                    ctl_d.err = 1'b1;
                end
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_BURST;
                    ctl_d.beat  = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - CNT_W'(1);
                end
            end
            ST_BURST: begin
                if (acc_cmd) begin
                    ctl_d.err = 1'b1;
                end
                if (ctl_q.beat == LAST_BEAT) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.beat  = '0;
                end else begin
                    ctl_d.beat = ctl_q.beat + BEAT_W'(1);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        // Mode loads only reach here while idle
        if (load_bad) begin
            ctl_d.err = 1'b1;
        end else if (load_ok) begin
            ctl_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.beat  <= '0;
            ctl_q.wr    <= 1'b0;
            ctl_q.start <= '0;
            ctl_q.err   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign idle   = (ctl_q.state == ST_IDLE);
    assign armed  = (ctl_q.state == ST_ARMED);
    assign active = (ctl_q.state == ST_BURST);
    assign wr     = ctl_q.wr;
    assign beat   = ctl_q.beat;
    assign start  = ctl_q.start;
    assign err    = ctl_q.err;

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
(
    input  logic              active,
    input  logic              il,
    input  logic [BEAT_W-1:0] start,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] col_lo
);

    logic [BEAT_W-1:0] seq_col;
    logic [BEAT_W-1:0] il_col;

    // Sequential: add without carry out of the aligned group
    // Interleaved: XOR each bit of the beat number into the start
    for (genvar b = 0; b < BEAT_W; b++) begin : g_bit
        assign il_col[b] = start[b] ^ beat[b];
    end

    always_comb begin
        seq_col = start + beat;
        col_lo  = '0;
        if (active) begin
            col_lo = il ? il_col : seq_col;
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter logic [2:0] RST_LAT_CODE   = 3'd4,
    parameter logic       RST_INTERLEAVE = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_load,
    input  logic [2:0] mode_lat_code,
    input  logic       mode_interleave,
    input  logic       acc_cmd,
    input  logic       acc_write,
    input  logic [1:0] col_start,
    input  logic       latch_cmd,
    output logic       rd_valid,
    output logic       wr_req,
    output logic [1:0] beat_idx,
    output logic [1:0] col_lo,
    output logic       err
);

    logic [LAT_W-1:0]  mode_code_q;
    logic              mode_il_q;
    logic              mode_valid_q;
    logic              load_ok;
    logic              load_bad;
    logic              ctrl_idle;
    logic              ctrl_armed;
    logic              ctrl_active;
    logic              ctrl_wr;
    logic [BEAT_W-1:0] ctrl_beat;
    logic [BEAT_W-1:0] ctrl_start;

    bcs_mode_reg #(
        .RST_CODE (RST_LAT_CODE),
        .RST_IL   (RST_INTERLEAVE)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (mode_load),
        .code_in  (mode_lat_code),
        .il_in    (mode_interleave),
        .allow    (ctrl_idle),
        .code_q   (mode_code_q),
        .il_q     (mode_il_q),
        .valid_q  (mode_valid_q),
        .load_ok  (load_ok),
        .load_bad (load_bad)
    );

    bcs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_cmd    (acc_cmd),
        .acc_write  (acc_write),
        .col_start  (col_start),
        .latch_cmd  (latch_cmd),
        .lat_code   (mode_code_q),
        .mode_valid (mode_valid_q),
        .load_ok    (load_ok),
        .load_bad   (load_bad),
        .idle       (ctrl_idle),
        .armed      (ctrl_armed),
        .active     (ctrl_active),
        .wr         (ctrl_wr),
        .beat       (ctrl_beat),
        .start      (ctrl_start),
        .err        (err)
    );

    bcs_addr_gen u_addr (
        .active (ctrl_active),
        .il     (mode_il_q),
        .start  (ctrl_start),
        .beat   (ctrl_beat),
        .col_lo (col_lo)
    );

    assign rd_valid = ctrl_active && !ctrl_wr;
    assign wr_req   = ctrl_active && ctrl_wr;
    assign beat_idx = ctrl_beat;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_load,
    input logic [2:0] mode_lat_code,
    input logic       idle,
    input logic       armed,
    input logic       latch_cmd,
    input logic       rd_valid,
    input logic       wr_req,
    input logic [1:0] beat_idx,
    input logic [1:0] col_lo,
    input logic       il,
    input logic [2:0] lat_code,
    input logic       err
);

    logic       on;
    logic [3:0] since;

    assign on = rd_valid || wr_req;

    // Cycles since the accepted latch command, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= 4'd0;
        end else if (latch_cmd && armed) begin
            since <= 4'd1;
        end else if (since != 4'd0 && since != 4'd15) begin
            since <= since + 4'd1;
        end
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_req)); // R3

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> since == {1'b0, lat_code}); // R2

    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> since == ({1'b0, lat_code} - 4'd1)); // R3

    AST_BEAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on) |-> beat_idx == 2'd0); // R4

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        on && beat_idx != 2'd3 |=> on && beat_idx == $past(beat_idx) + 2'd1); // R4

    AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
        on && beat_idx == 2'd3 |=> !on); // R2

    AST_SEQ_COL: assert property (@(posedge clk) disable iff (!rst_n)
        on && beat_idx != 2'd0 && !il |-> col_lo == $past(col_lo) + 2'd1); // R5

    AST_IL_COL: assert property (@(posedge clk) disable iff (!rst_n)
        on && beat_idx != 2'd0 && il
        |-> col_lo == ($past(col_lo) ^ (beat_idx ^ (beat_idx - 2'd1)))); // R6

    AST_RESERVED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load && idle && !mode_lat_code[2] |=> err); // R7

endmodule

bind burst_col_seq bcs_checker u_bcs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_load     (mode_load),
    .mode_lat_code (mode_lat_code),
    .idle          (ctrl_idle),
    .armed         (ctrl_armed),
    .latch_cmd     (latch_cmd),
    .rd_valid      (rd_valid),
    .wr_req        (wr_req),
    .beat_idx      (beat_idx),
    .col_lo        (col_lo),
    .il            (mode_il_q),
    .lat_code      (mode_code_q),
    .err           (err)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_lat_code = 3'd4;
    logic       mode_interleave = 1'b0;
    logic       acc_cmd = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] col_start = 2'd0;
    logic       latch_cmd = 1'b0;
    logic       rd_valid;
    logic       wr_req;
    logic [1:0] beat_idx;
    logic [1:0] col_lo;
    logic       err;

    typedef struct packed {
        int         due;
        logic       wr;
        logic [1:0] beat;
        logic [1:0] col;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    int    unexpected = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    burst_col_seq u_burst_col_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_load       (mode_load),
        .mode_lat_code   (mode_lat_code),
        .mode_interleave (mode_interleave),
        .acc_cmd         (acc_cmd),
        .acc_write       (acc_write),
        .col_start       (col_start),
        .latch_cmd       (latch_cmd),
        .rd_valid        (rd_valid),
        .wr_req          (wr_req),
        .beat_idx        (beat_idx),
        .col_lo          (col_lo),
        .err             (err)
    );

    // Monitor: one sample per cycle, 2 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (rst_n && (rd_valid || wr_req)) begin
                if (sb_q.size() == 0) begin
                    unexpected++;
                    failures++;
                    $display("FAIL R8/R9: unexpected beat at cycle %0d rd=%0b wr=%0b col=%0d, expected none",
                             cyc, rd_valid, wr_req, col_lo);
                end else begin
                    exp_t  e;
                    string t;
                    e = sb_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (e.due != cyc || e.wr != wr_req || e.wr == rd_valid ||
                        e.beat != beat_idx || e.col != col_lo) begin
                        failures++;
                        $display("FAIL %s: cyc=%0d wr=%0b beat=%0d col=%0d, expected cyc=%0d wr=%0b beat=%0d col=%0d",
                                 t, cyc, wr_req, beat_idx, col_lo, e.due, e.wr, e.beat, e.col);
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_mode(input logic [2:0] code, input logic il);
        @(negedge clk);
        mode_load = 1'b1;
        mode_lat_code = code;
        mode_interleave = il;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    task automatic pulse_acc(input logic wr, input logic [1:0] st);
        @(negedge clk);
        acc_cmd = 1'b1;
        acc_write = wr;
        col_start = st;
        @(negedge clk);
        acc_cmd = 1'b0;
    endtask

    // Drive latch now (current negedge) and queue the expected beats
    task automatic latch_and_expect(input bit expect_burst, input logic wr, input logic [1:0] st,
                                    input int lat, input bit il, input string tag);
        latch_cmd = 1'b1;
        if (expect_burst) begin
            for (int k = 0; k < 4; k++) begin
                exp_t e;
                e.due  = cyc + (wr ? lat - 1 : lat) + k;
                e.wr   = wr;
                e.beat = 2'(k);
                e.col  = il ? (st ^ 2'(k)) : 2'(st + 2'(k));
                sb_q.push_back(e);
                tag_q.push_back(tag);
            end
        end
        @(negedge clk);
        latch_cmd = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [1:0] st, input int gap,
                          input int lat, input bit il, input string tag);
        pulse_acc(wr, st);
        tick(gap);
        latch_and_expect(1'b1, wr, st, lat, il, tag);
        tick(lat + 4);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check(rd_valid == 1'b0 && wr_req == 1'b0, "R1 strobes", {rd_valid, wr_req}, 0);
        check(beat_idx == 2'd0 && col_lo == 2'd0, "R1 beat/col", {beat_idx, col_lo}, 0);
        check(err == 1'b0, "R1 err", err, 0);
        // R1 reset mode is latency 4 sequential; R2 read, R5 wrap
        access(1'b0, 2'd1, 0, 4, 1'b0, "R1/R2/R5 read L4 seq");
        // R3 write, R5
        access(1'b1, 2'd2, 2, 4, 1'b0, "R3/R5 write L4 seq");
        // R2 latency from latch, not from access: long gap
        access(1'b0, 2'd3, 6, 4, 1'b0, "R2 gap read");
        // R6 interleave, latency 7
        load_mode(3'd7, 1'b1);
        check(err == 1'b0, "R7 legal load err", err, 0);
        access(1'b0, 2'd2, 1, 7, 1'b1, "R2/R6 read L7 il");
        access(1'b0, 2'd1, 0, 7, 1'b1, "R4/R6 read L7 il start1");
        load_mode(3'd5, 1'b1);
        access(1'b1, 2'd3, 0, 5, 1'b1, "R3/R6 write L5 il");
        load_mode(3'd6, 1'b0);
        access(1'b1, 2'd0, 3, 6, 1'b0, "R3/R4 write L6 seq");
        // R8: latch without pending access
        @(negedge clk);
        latch_and_expect(1'b0, 1'b0, 2'd0, 6, 1'b0, "R8");
        tick(12);
        check(unexpected == 0, "R8 no burst after lone latch", unexpected, 0);
        check(err == 1'b0, "R8 err unchanged", err, 0);
        // R9: second access while armed -> err, first access still runs
        pulse_acc(1'b0, 2'd1);
        pulse_acc(1'b1, 2'd3);
        check(err == 1'b1, "R9 err after access while armed", err, 1);
        latch_and_expect(1'b1, 1'b0, 2'd1, 6, 1'b0, "R9 original read kept");
        tick(10);
        load_mode(3'd4, 1'b0);
        check(err == 1'b0, "R9 err cleared by legal load", err, 0);
        // R9: access during burst
        pulse_acc(1'b0, 2'd0);
        latch_and_expect(1'b1, 1'b0, 2'd0, 4, 1'b0, "R9 read in flight");
        tick(4);
        pulse_acc(1'b1, 2'd2);
        check(err == 1'b1, "R9 err after access during burst", err, 1);
        tick(12);
        check(unexpected == 0, "R9 rejected access gave no burst", unexpected, 0);
        load_mode(3'd4, 1'b0);
        // R10: mode load during counting ignored
        pulse_acc(1'b0, 2'd1);
        latch_and_expect(1'b1, 1'b0, 2'd1, 4, 1'b0, "R10 burst during load");
        load_mode(3'd7, 1'b1);
        tick(8);
        access(1'b0, 2'd2, 0, 4, 1'b0, "R10 mode kept L4 seq");
        // R7: reserved code
        load_mode(3'd2, 1'b1);
        check(err == 1'b1, "R7 err after reserved load", err, 1);
        pulse_acc(1'b0, 2'd1);
        latch_and_expect(1'b0, 1'b0, 2'd1, 2, 1'b1, "R7");
        tick(12);
        check(unexpected == 0, "R7 access ignored under reserved code", unexpected, 0);
        check(err == 1'b1, "R7 err held", err, 1);
        load_mode(3'd5, 1'b0);
        check(err == 1'b0, "R7 err cleared", err, 0);
        access(1'b0, 2'd3, 0, 5, 1'b0, "R7 access after legal reload");
        tick(4);
        check(sb_q.size() == 0, "R2 all expected beats seen", sb_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule